// File: doc/BRIEF.md
# Paged Program Counter with High-Byte Staging Latch

This block holds the fetch address of a small 8-bit controller core. The counter is 16 bits wide. Its low byte is exposed as an ordinary data-memory register. The high byte has no address of its own, and software reaches it only through an 8-bit staging latch that is also mapped in data memory.

Every cycle the core's sequencer presents at most a few requests:
- fetch increment
- skip
- absolute jump or call carrying a 13-bit opcode field
- long call carrying an 8-bit opcode field
- return with the top-of-stack value
- interrupt vector load
- register-file read or write aimed at either the low byte or the latch

The block resolves these requests by a fixed priority and updates the counter and the latch on the rising clock edge. On a call it presents the return address so that an external stack can store it. Stack storage, decode, ALU and program memory stay outside the block; their results arrive on ports.

The latch is as wide as one data word and the counter is two data words wide. Absolute jumps replace the low `ABS_W` bits of the counter and keep the bits above them.

Top module: `pcl_top`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` reads 0000h and the latch reads 00h. Reset is asynchronous.
- R2: With only `fetch_en` high, the counter advances by one per clock and wraps from FFFFh to 0000h. With no request at all, the counter holds its value.
- R3: `reg_rdata` follows the current register values without a clock. When `reg_sel`=0 it shows counter bits 7:0. When `reg_sel`=1 it shows the latch.
- R4: A read of the low byte (`reg_rd_en`=1, `reg_sel`=0) copies counter bits 15:8 into the latch at the clock edge. This applies when no write or redirect is present.
- R5: A write to the low byte (`reg_wr_en`=1, `reg_sel`=0) sets the counter to {latch, `reg_wdata`}. A write to the latch (`reg_sel`=1) changes only the latch.
- R6: A read and a write to the low byte in the same cycle (read-modify-write) set the counter to {old latch, `reg_wdata`} and leave the latch unchanged.
- R7: A jump or call (`goto_en` or `call_en`) has the following effect:
  - Counter bits 12:0 take `opcode`, and counter bits 15:13 keep their value.
  - Latch bits 4:0 take `opcode` bits 12:8, and latch bits 7:5 keep their value.
- R8: A long call sets the counter to {latch, `opcode` bits 7:0} and leaves the latch unchanged.
- R9: A call or long call that is taken raises `push_en` in that cycle, with `push_data` equal to the current `fetch_addr` plus one.
- R10: A return loads the counter from `stack_top` and leaves the latch unchanged.
- R11: An interrupt loads the counter from `irq_vector`, leaves the latch unchanged and raises no push. It overrides every other request.
- R12: With `skip_en` high and no interrupt, the counter advances by one. All jump, call, return and register-write requests of that cycle are ignored, and no push is raised.
- R13: When no interrupt or skip is present, the priority is return, then jump/call/long call, then low-byte write, then increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Advance the counter after a fetch |
| skip_en | input | 1 | Current instruction is squashed into a no-operation |
| goto_en | input | 1 | Absolute jump request |
| call_en | input | 1 | Absolute call request |
| lcall_en | input | 1 | Long call request |
| ret_en | input | 1 | Return request, load from `stack_top` |
| irq_en | input | 1 | Interrupt vector load |
| opcode | input | 13 | Destination field from the instruction |
| stack_top | input | 16 | Most recently pushed stack entry |
| irq_vector | input | 16 | Interrupt entry address |
| reg_rd_en | input | 1 | Register-file read of a mapped register |
| reg_wr_en | input | 1 | Register-file write of a mapped register |
| reg_sel | input | 1 | 0 selects the low byte, 1 selects the latch |
| reg_wdata | input | 8 | Write data or ALU result |
| fetch_addr | output | 16 | Current counter value |
| reg_rdata | output | 8 | Read data of the selected mapped register |
| push_en | output | 1 | Store `push_data` on the external stack |
| push_data | output | 16 | Return address for a call |

## Verification
The hardest cases to reach are the two in which the latch and the counter's high byte must hold different values.

The first is the read-modify-write. It only shows that the old latch is used if the counter's high byte differs from the latch beforehand. The stimulus therefore first writes a full address through the latch, then reloads the latch with another value, and only then issues the combined read and write.

The second is the jump's partial latch update, which needs nonzero upper latch bits and nonzero upper counter bits. Both are seeded the same way before the jump.

Collisions of several requests in one cycle are driven as single vectors, so each priority pairing is seen in isolation.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  // Source of the next counter value
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_INC,
    SRC_LOWWR,
    SRC_ABS,
    SRC_LONG,
    SRC_STACK,
    SRC_VEC
  } pc_src_e;

  // How the staging latch is updated
  typedef enum logic [1:0] {
    LAT_HOLD,
    LAT_ABS,
    LAT_COPY,
    LAT_WR
  } lat_mode_e;

  // Register select encoding on the register-file side
  localparam logic SEL_LOW   = 1'b0;
  localparam logic SEL_LATCH = 1'b1;

endpackage

// File: rtl/pcl_src_sel.sv
module pcl_src_sel
  import pcl_pkg::*;
(
  input  logic      fetch_en,
  input  logic      skip_en,
  input  logic      goto_en,
  input  logic      call_en,
  input  logic      lcall_en,
  input  logic      ret_en,
  input  logic      irq_en,
  input  logic      reg_rd_en,
  input  logic      reg_wr_en,
  input  logic      reg_sel,
  output pc_src_e   src,
  output lat_mode_e lat_mode,
  output logic      push
);

  logic low_rd;
  logic low_wr;
  logic lat_wr;

  assign low_rd = reg_rd_en && (reg_sel == SEL_LOW);
  assign low_wr = reg_wr_en && (reg_sel == SEL_LOW);
  assign lat_wr = reg_wr_en && (reg_sel == SEL_LATCH);

  always_comb begin
    src      = SRC_HOLD;
    lat_mode = LAT_HOLD;
    push     = 1'b0;
    if (irq_en) begin
      src = SRC_VEC;
    end else if (skip_en) begin
      src = SRC_INC;
    end else if (ret_en) begin
      src = SRC_STACK;
    end else if (goto_en || call_en) begin
      src      = SRC_ABS;
      lat_mode = LAT_ABS;
      push     = call_en;
    end else if (lcall_en) begin
      src  = SRC_LONG;
      push = 1'b1;
    end else if (low_wr) begin
      src = SRC_LOWWR;
    end else begin
      src = fetch_en ? SRC_INC : SRC_HOLD;
      if (low_rd) begin
        lat_mode = LAT_COPY;
      end else if (lat_wr) begin
        lat_mode = LAT_WR;
      end
    end
  end

endmodule

// File: rtl/pcl_next_calc.sv
module pcl_next_calc
  import pcl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ABS_W  = 13,
  localparam int PC_W  = 2 * DATA_W
) (
  input  pc_src_e           src,
  input  lat_mode_e         lat_mode,
  input  logic [PC_W-1:0]   pc_q,
  input  logic [DATA_W-1:0] lat_q,
  input  logic [ABS_W-1:0]  opcode,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PC_W-1:0]   stack_top,
  input  logic [PC_W-1:0]   irq_vector,
  output logic [PC_W-1:0]   pc_nxt,
  output logic [DATA_W-1:0] lat_nxt,
  output logic [PC_W-1:0]   pc_inc
);

  localparam int LAT_KEEP = PC_W - ABS_W;

  assign pc_inc = pc_q + {{(PC_W-1){1'b0}}, 1'b1};

  always_comb begin
    pc_nxt = pc_q;
    unique case (src)
      SRC_INC:   pc_nxt = pc_inc;
      SRC_LOWWR: pc_nxt = {lat_q, wdata};
      SRC_ABS:   pc_nxt = {pc_q[PC_W-1:ABS_W], opcode};
      SRC_LONG:  pc_nxt = {lat_q, opcode[DATA_W-1:0]};
      SRC_STACK: pc_nxt = stack_top;
      SRC_VEC:   pc_nxt = irq_vector;
      default:   pc_nxt = pc_q;
    endcase
  end

  always_comb begin
    lat_nxt = lat_q;
    unique case (lat_mode)
      LAT_ABS:  lat_nxt = {lat_q[DATA_W-1:DATA_W-LAT_KEEP], opcode[ABS_W-1:DATA_W]};
      LAT_COPY: lat_nxt = pc_q[PC_W-1:DATA_W];
      LAT_WR:   lat_nxt = wdata;
      default:  lat_nxt = lat_q;
    endcase
  end

endmodule

// File: rtl/pcl_top.sv
module pcl_top
  import pcl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ABS_W  = 13,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              skip_en,
  input  logic              goto_en,
  input  logic              call_en,
  input  logic              lcall_en,
  input  logic              ret_en,
  input  logic              irq_en,
  input  logic [ABS_W-1:0]  opcode,
  input  logic [PC_W-1:0]   stack_top,
  input  logic [PC_W-1:0]   irq_vector,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [PC_W-1:0]   fetch_addr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              push_en,
  output logic [PC_W-1:0]   push_data
);

  pc_src_e           src;
  lat_mode_e         lat_mode;
  logic              push;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_nxt;
  logic [PC_W-1:0]   pc_inc;
  logic [DATA_W-1:0] lat_q;
  logic [DATA_W-1:0] lat_nxt;
  logic              pc_ce;
  logic              lat_ce;

  pcl_src_sel u_sel (
    .fetch_en  (fetch_en),
    .skip_en   (skip_en),
    .goto_en   (goto_en),
    .call_en   (call_en),
    .lcall_en  (lcall_en),
    .ret_en    (ret_en),
    .irq_en    (irq_en),
    .reg_rd_en (reg_rd_en),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .src       (src),
    .lat_mode  (lat_mode),
    .push      (push)
  );

  pcl_next_calc #(
    .DATA_W (DATA_W),
    .ABS_W  (ABS_W)
  ) u_calc (
    .src        (src),
    .lat_mode   (lat_mode),
    .pc_q       (pc_q),
    .lat_q      (lat_q),
    .opcode     (opcode),
    .wdata      (reg_wdata),
    .stack_top  (stack_top),
    .irq_vector (irq_vector),
    .pc_nxt     (pc_nxt),
    .lat_nxt    (lat_nxt),
    .pc_inc     (pc_inc)
  );

  assign pc_ce  = (src != SRC_HOLD);
  assign lat_ce = (lat_mode != LAT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_ce) begin
      pc_q <= pc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_ce) begin
      lat_q <= lat_nxt;
    end
  end

  assign fetch_addr = pc_q;
  assign reg_rdata  = (reg_sel == SEL_LATCH) ? lat_q : pc_q[DATA_W-1:0];
  assign push_en    = push;
  assign push_data  = pc_inc;

  // Marks cycles whose inputs were sampled out of reset
  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
    end
  end

  logic hi_free;
  assign hi_free = !irq_en && !skip_en;

  assert_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && irq_en |=> (pc_q == $past(irq_vector)) && $stable(lat_q));

  assert_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && hi_free && ret_en |=> (pc_q == $past(stack_top)) && $stable(lat_q));

  assert_abs_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && hi_free && !ret_en && (goto_en || call_en)
    |=> (pc_q[PC_W-1:ABS_W] == $past(pc_q[PC_W-1:ABS_W]))
        && (pc_q[ABS_W-1:0] == $past(opcode)));

  assert_low_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && hi_free && !ret_en && !goto_en && !call_en && !lcall_en
    && reg_wr_en && (reg_sel == SEL_LOW)
    |=> (pc_q == {$past(lat_q), $past(reg_wdata)}));

  assert_skip_inc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && skip_en && !irq_en |=> (pc_q == PC_W'($past(pc_q) + 1'b1)));

  assert_push_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !irq_en && !skip_en && !ret_en && (call_en || lcall_en));

endmodule

// File: tb/pcl_top_tb.sv
module pcl_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        fetch_en, skip_en, goto_en, call_en, lcall_en, ret_en, irq_en;
  logic [12:0] opcode;
  logic [15:0] stack_top;
  logic [15:0] irq_vector;
  logic        reg_rd_en, reg_wr_en, reg_sel;
  logic [7:0]  reg_wdata;
  logic [15:0] fetch_addr;
  logic [7:0]  reg_rdata;
  logic        push_en;
  logic [15:0] push_data;

  int checks;
  int failures;

  pcl_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_en   (fetch_en),
    .skip_en    (skip_en),
    .goto_en    (goto_en),
    .call_en    (call_en),
    .lcall_en   (lcall_en),
    .ret_en     (ret_en),
    .irq_en     (irq_en),
    .opcode     (opcode),
    .stack_top  (stack_top),
    .irq_vector (irq_vector),
    .reg_rd_en  (reg_rd_en),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .fetch_addr (fetch_addr),
    .reg_rdata  (reg_rdata),
    .push_en    (push_en),
    .push_data  (push_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // control bits: fetch skip goto call lcall ret irq rd wr sel
  typedef struct packed {
    logic [9:0]  c;
    logic [12:0] op;
    logic [7:0]  wd;
    logic [15:0] stk;
    logic [15:0] epc;
    logic [7:0]  elat;
    logic        epush;
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 27;
  localparam row_t TBL [NROWS] = '{
    '{10'b1000000000, 13'h0000, 8'h00, 16'h0000, 16'h0001, 8'h00, 1'b0, 4'd2},  // R2
    '{10'b1000000000, 13'h0000, 8'h00, 16'h0000, 16'h0002, 8'h00, 1'b0, 4'd2},  // R2
    '{10'b0000000011, 13'h0000, 8'h12, 16'h0000, 16'h0002, 8'h12, 1'b0, 4'd5},  // R5 latch write
    '{10'b0000000010, 13'h0000, 8'hF0, 16'h0000, 16'h12F0, 8'h12, 1'b0, 4'd5},  // R5 low write
    '{10'b0000000011, 13'h0000, 8'h03, 16'h0000, 16'h12F0, 8'h03, 1'b0, 4'd5},
    '{10'b0000000110, 13'h0000, 8'h20, 16'h0000, 16'h0320, 8'h03, 1'b0, 4'd6},  // R6 rmw
    '{10'b0000000011, 13'h0000, 8'h7A, 16'h0000, 16'h0320, 8'h7A, 1'b0, 4'd5},
    '{10'b0000000100, 13'h0000, 8'h00, 16'h0000, 16'h0320, 8'h03, 1'b0, 4'd4},  // R4 copy
    '{10'b0000000011, 13'h0000, 8'hA5, 16'h0000, 16'h0320, 8'hA5, 1'b0, 4'd5},
    '{10'b0000000010, 13'h0000, 8'h00, 16'h0000, 16'hA500, 8'hA5, 1'b0, 4'd5},
    '{10'b0000000011, 13'h0000, 8'hE5, 16'h0000, 16'hA500, 8'hE5, 1'b0, 4'd5},
    '{10'b0010000000, 13'h1ABC, 8'h00, 16'h0000, 16'hBABC, 8'hFA, 1'b0, 4'd7},  // R7 jump
    '{10'b0001000000, 13'h0123, 8'h00, 16'h0000, 16'hA123, 8'hE1, 1'b1, 4'd9},  // R9 call
    '{10'b0000100000, 13'h0077, 8'h00, 16'h0000, 16'hE177, 8'hE1, 1'b1, 4'd8},  // R8 long call
    '{10'b0000010000, 13'h0000, 8'h00, 16'h4455, 16'h4455, 8'hE1, 1'b0, 4'd10}, // R10
    '{10'b1001001000, 13'h0123, 8'h00, 16'h0000, 16'h0028, 8'hE1, 1'b0, 4'd11}, // R11
    '{10'b0001010000, 13'h0123, 8'h00, 16'h1000, 16'h1000, 8'hE1, 1'b0, 4'd13}, // R13 ret>call
    '{10'b1010000010, 13'h0005, 8'h99, 16'h0000, 16'h0005, 8'hE0, 1'b0, 4'd13}, // R13 jump>write
    '{10'b1000000010, 13'h0000, 8'h44, 16'h0000, 16'hE044, 8'hE0, 1'b0, 4'd13}, // R13 write>inc
    '{10'b1110000011, 13'h1FFF, 8'h11, 16'h0000, 16'hE045, 8'hE0, 1'b0, 4'd12}, // R12
    '{10'b0101000000, 13'h0001, 8'h00, 16'h0000, 16'hE046, 8'hE0, 1'b0, 4'd12}, // R12 no push
    '{10'b0100001000, 13'h0000, 8'h00, 16'h0000, 16'h0028, 8'hE0, 1'b0, 4'd11}, // R11 over skip
    '{10'b0000000000, 13'h0000, 8'h00, 16'h0000, 16'h0028, 8'hE0, 1'b0, 4'd2},  // R2 hold
    '{10'b0000000011, 13'h0000, 8'hFF, 16'h0000, 16'h0028, 8'hFF, 1'b0, 4'd5},
    '{10'b0000000010, 13'h0000, 8'hFF, 16'h0000, 16'hFFFF, 8'hFF, 1'b0, 4'd5},
    '{10'b1000000000, 13'h0000, 8'h00, 16'h0000, 16'h0000, 8'hFF, 1'b0, 4'd2},  // R2 wrap
    '{10'b1000000100, 13'h0000, 8'h00, 16'h0000, 16'h0001, 8'h00, 1'b0, 4'd4}   // R4 with fetch
  };

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {fetch_en, skip_en, goto_en, call_en, lcall_en, ret_en, irq_en} = '0;
    reg_rd_en = 1'b0;
    reg_wr_en = 1'b0;
    reg_sel   = 1'b1;
    opcode    = '0;
    stack_top = '0;
    reg_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] prev_pc;
    checks = 0;
    failures = 0;
    irq_vector = 16'h0028;
    idle_inputs();
    rst_n = 1'b0;
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    check16("R1 pc in reset", fetch_addr, 16'h0000);
    check16("R1 latch in reset", {8'h00, reg_rdata}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    prev_pc = 16'h0000;
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      {fetch_en, skip_en, goto_en, call_en, lcall_en, ret_en, irq_en,
       reg_rd_en, reg_wr_en, reg_sel} = TBL[i].c;
      opcode    = TBL[i].op;
      reg_wdata = TBL[i].wd;
      stack_top = TBL[i].stk;
      #1;
      check16($sformatf("R%0d row %0d push_en", TBL[i].req, i),
              {15'd0, push_en}, {15'd0, TBL[i].epush});
      if (TBL[i].epush) begin
        check16($sformatf("R9 row %0d push_data", i), push_data, prev_pc + 16'd1);
      end
      @(posedge clk);
      #1;
      idle_inputs();
      #1;
      check16($sformatf("R%0d row %0d pc", TBL[i].req, i), fetch_addr, TBL[i].epc);
      check16($sformatf("R%0d row %0d latch", TBL[i].req, i), {8'h00, reg_rdata},
              {8'h00, TBL[i].elat});
      prev_pc = TBL[i].epc;
    end

    // R3 combinational read mux, no clock edge between selections (pc 0001, latch 00)
    @(negedge clk);
    reg_sel = 1'b0;
    #1;
    check16("R3 low byte read", {8'h00, reg_rdata}, 16'h0001);
    reg_sel = 1'b1;
    #1;
    check16("R3 latch read", {8'h00, reg_rdata}, 16'h0000);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    fetch_en = 1'b1;
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check16("R1 async reset pc", fetch_addr, 16'h0000);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check16("R2 hold after reset", fetch_addr, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule